// File: doc/BRIEF.md
# Four-Phase Interleaved PWM Generator

The block produces four gate-drive PWM lines that share one circulating timing reference. The reference is an 8-bit tap counter. It advances once per tap clock and wraps once per switching period, so the period is 256 taps long and duty has 8 bits of resolution. The four phase starts are spread evenly around the period, 64 taps apart. Each phase goes high when the reference reaches its own start tap. It goes low when the reference reaches that start tap plus the commanded duty. The sum is taken modulo 256, so a pulse that crosses the wrap point still ends on time.

Duty commands arrive as an 8-bit value with a valid strobe. They are stored in one of two holding registers. One register is current and the other is a shadow. A new command always goes to the shadow. At the next pass through tap zero the roles swap. Each phase captures which register was current when it started, and it reads its stop point from that register until it ends. If the shadow is still being read by a pulse that began before the last swap, a new command waits in a one-entry hold and is written once that pulse ends. A pulse that is already running therefore never sees its duty change. Each phase also gives a one-cycle turn-off strobe when its line falls.

Top module: `tap_pwm_quad`

## Requirements
- R1: While reset is asserted, every PWM and turn-off output is low and the reference sits at tap 255. The first clock after release moves the reference to tap 0. Commands presented in that first tap-255 cycle and in the first tap-0 cycle are discarded. No phase can start before the second pass through tap 0.
- R2: Phase k (k = 0..3) starts at tap 64·k. When its duty is non-zero, its output is high from the cycle in which the reference reads 64·k+1.
- R3: A pulse with duty d (1..254) is high for exactly d consecutive tap cycles. The last high cycle is the one in which the reference reads (64·k + d) mod 256, which holds for pulses that cross the wrap too.
- R4: A duty of 0 keeps the phase low for the whole period and produces no turn-off strobe.
- R5: A duty of 255 keeps the phase high through its next start tap. If the next command is also 255, the line stays high without a break.
- R6: In the cycle after a PWM line falls, its turn-off strobe is high for exactly one cycle. It is low at all other times.
- R7: A command never changes the width of a pulse that started before the command took effect. Every pulse ends at the stop tap given by the duty that was current at its start.
- R8: An accepted command takes effect from the next tap-0 pass. If several commands arrive before that pass, the last one is used.
- R9: While the shadow register is still read by a running pulse from the previous period, a new command is held. It is written once that pulse has ended and takes effect at the tap-0 pass after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tap clock; one edge per reference tap |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | 8 | Duty command in taps (0 = off, 255 = held on) |
| duty_vld_i | input | 1 | Strobe; duty_i is taken in this cycle |
| pwm_o | output | 4 | Gate PWM lines; bit k is phase k |
| off_o | output | 4 | One-cycle turn-off strobe per phase |

## Verification
Directed sequences check pulse edges and widths at specific taps. They cover a mid-range duty, a pulse of phase 3 that crosses the wrap, zero duty, and a held full duty, which separates correct modulo stop arithmetic from plain comparison and separates the two special duty codes from normal ones. A burst of commands sent just after a swap, while a long pulse from the previous period is still running, shows whether a write is deferred or lands in a register that is still being read. Two commands within one period show whether the last one wins. Random commands, with extra weight on 0 and 255 and sent at random taps, are then compared cycle by cycle against a model of the register swap and hold rules.

// File: rtl/tap_pwm_pkg.sv
package tap_pwm_pkg;
  localparam int TAP_W  = 8;
  localparam int N_PH   = 4;
  localparam int N_BANK = 2;

  // even spacing of phase start taps around the reference
  function automatic int start_of(input int ph, input int tap_w, input int n_ph);
    return (ph * ((1 << tap_w) / n_ph)) % (1 << tap_w);
  endfunction
endpackage

// File: rtl/tap_pwm_ref.sv
module tap_pwm_ref #(
  parameter int TAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TAP_W-1:0] tap_o,
  output logic             wrap_o,
  output logic             armed_o
);
  logic [TAP_W-1:0] tap_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q   <= '1;
      armed_q <= 1'b0;
    end else begin
      tap_q   <= tap_q + 1'b1;
      if (tap_q == '0) armed_q <= 1'b1;
    end
  end

  assign tap_o   = tap_q;
  assign wrap_o  = (tap_q == '0);
  assign armed_o = armed_q;

  AST_ARM_AFTER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_q == '0) |=> armed_q); // R1
endmodule

// File: rtl/tap_pwm_cmd.sv
module tap_pwm_cmd #(
  parameter int TAP_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  armed_i,
  input  logic                  wrap_i,
  input  logic [TAP_W-1:0]      cmd_i,
  input  logic                  cmd_vld_i,
  input  logic [1:0]            busy_i,
  output logic                  sel_now_o,
  output logic [1:0][TAP_W-1:0] bank_o
);
  logic [1:0][TAP_W-1:0] bank_q;
  logic                  cur_q, pend_q, hold_vld_q;
  logic [TAP_W-1:0]      hold_q;
  logic                  sel_now, tgt, have, do_wr, park;
  logic [TAP_W-1:0]      wr_data;

  // swap happens in the tap-0 cycle itself so phase 0 sees the new value
  assign sel_now = (wrap_i && pend_q) ? ~cur_q : cur_q;
  assign tgt     = ~sel_now;
  assign have    = armed_i && (cmd_vld_i || hold_vld_q);
  assign wr_data = cmd_vld_i ? cmd_i : hold_q;
  assign do_wr   = have && !busy_i[tgt];
  assign park    = have && busy_i[tgt];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q     <= '0;
      cur_q      <= 1'b0;
      pend_q     <= 1'b0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      cur_q <= sel_now;
      if (do_wr) begin
        bank_q[tgt] <= wr_data;
        hold_vld_q  <= 1'b0;
        pend_q      <= 1'b1;
      end else begin
        if (wrap_i) pend_q <= 1'b0;
        if (park) begin
          hold_q     <= wr_data;
          hold_vld_q <= 1'b1;
        end
      end
    end
  end

  assign sel_now_o = sel_now;
  assign bank_o    = bank_q;

  AST_BUSY0_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i[0] |=> $stable(bank_q[0])); // R9
  AST_BUSY1_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i[1] |=> $stable(bank_q[1])); // R9
  AST_IGNORE_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> $stable(bank_q)); // R1
endmodule

// File: rtl/tap_pwm_phase.sv
module tap_pwm_phase #(
  parameter int               TAP_W = 8,
  parameter logic [TAP_W-1:0] START = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [TAP_W-1:0]      tap_i,
  input  logic                  armed_i,
  input  logic                  sel_now_i,
  input  logic [1:0][TAP_W-1:0] bank_i,
  output logic                  pwm_o,
  output logic                  off_o,
  output logic                  sel_o
);
  logic             pwm_q, pwm_d, sel_q, sel_d, off_q;
  logic             start_hit, full;
  logic [TAP_W-1:0] duty_new, held_duty, stop_tap;

  assign start_hit = armed_i && (tap_i == START);
  assign duty_new  = bank_i[sel_now_i];
  assign held_duty = bank_i[sel_q];
  assign stop_tap  = START + held_duty;  // wraps modulo the period
  assign full      = &held_duty;

  always_comb begin
    pwm_d = pwm_q;
    sel_d = sel_q;
    if (start_hit) begin
      pwm_d = |duty_new;
      sel_d = sel_now_i;
    end else if (pwm_q && !full && (tap_i == stop_tap)) begin
      pwm_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
      sel_q <= 1'b0;
      off_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
      sel_q <= sel_d;
      off_q <= pwm_q & ~pwm_d;
    end
  end

  assign pwm_o = pwm_q;
  assign off_o = off_q;
  assign sel_o = sel_q;

  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> ($past(tap_i) == START)); // R2
  AST_FALL_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_q) |-> (($past(tap_i) == $past(stop_tap)) || ($past(tap_i) == START))); // R3
  AST_ZERO_STAYS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_hit && (duty_new == '0)) |=> !pwm_q); // R4
  AST_FULL_STAYS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_q && full && !start_hit) |=> pwm_q); // R5
  AST_OFF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |=> !off_q); // R6
  AST_HELD_DUTY_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_q && !start_hit) |=> $stable(held_duty)); // R7
endmodule

// File: rtl/tap_pwm_quad.sv
module tap_pwm_quad #(
  parameter int TAP_W = tap_pwm_pkg::TAP_W,
  parameter int N_PH  = tap_pwm_pkg::N_PH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAP_W-1:0] duty_i,
  input  logic             duty_vld_i,
  output logic [N_PH-1:0]  pwm_o,
  output logic [N_PH-1:0]  off_o
);
  logic [TAP_W-1:0]      tap;
  logic                  wrap, armed, sel_now;
  logic [1:0][TAP_W-1:0] bank;
  logic [N_PH-1:0]       pwm, off, ph_sel;
  logic [1:0]            busy;

  tap_pwm_ref #(.TAP_W(TAP_W)) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tap_o   (tap),
    .wrap_o  (wrap),
    .armed_o (armed)
  );

  tap_pwm_cmd #(.TAP_W(TAP_W)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .armed_i   (armed),
    .wrap_i    (wrap),
    .cmd_i     (duty_i),
    .cmd_vld_i (duty_vld_i),
    .busy_i    (busy),
    .sel_now_o (sel_now),
    .bank_o    (bank)
  );

  for (genvar g = 0; g < N_PH; g++) begin : g_ph
    localparam logic [TAP_W-1:0] ST = TAP_W'(tap_pwm_pkg::start_of(g, TAP_W, N_PH));
    tap_pwm_phase #(.TAP_W(TAP_W), .START(ST)) u_ph (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tap_i     (tap),
      .armed_i   (armed),
      .sel_now_i (sel_now),
      .bank_i    (bank),
      .pwm_o     (pwm[g]),
      .off_o     (off[g]),
      .sel_o     (ph_sel[g])
    );
  end

  // a register is busy while any running pulse still reads its stop from it
  always_comb begin
    busy = '0;
    for (int k = 0; k < N_PH; k++) begin
      if (pwm[k]) busy[ph_sel[k]] = 1'b1;
    end
  end

  assign pwm_o = pwm;
  assign off_o = off;

  AST_QUIET_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> ((pwm_o == '0) && (off_o == '0))); // R1
  AST_OFF_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_o != '0) |-> ((off_o & ~pwm_o) == off_o)); // R6
endmodule

// File: tb/sim_tap_pwm_quad.sv
module sim_tap_pwm_quad;
  localparam int CLK_P = 10;
  localparam int NP    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] duty = '0;
  logic       vld = 1'b0;
  logic [3:0] pwm_o, off_o;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  tap_pwm_quad u0 (
    .clk_i(clk), .rst_ni(rst_n), .duty_i(duty), .duty_vld_i(vld),
    .pwm_o(pwm_o), .off_o(off_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model built from the requirements
  int b_tap, m_arm, m_cur, m_pend, m_hold, m_hv;
  int m_bank[2];
  int m_on[NP], m_sel[NP], m_off[NP];
  int t_sn, t_tgt, t_busy, t_have, t_d, t_wr, t_b;
  int n_on[NP], n_sel[NP];

  function automatic int start_tap(input int k);
    return 64 * k;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_tap = 255; m_arm = 0; m_cur = 0; m_pend = 0; m_hold = 0; m_hv = 0;
      m_bank[0] = 0; m_bank[1] = 0;
      for (int k = 0; k < NP; k++) begin m_on[k] = 0; m_sel[k] = 0; m_off[k] = 0; end
    end else begin
      t_sn = (b_tap == 0 && m_pend != 0) ? 1 - m_cur : m_cur;
      t_wr = 0;
      for (int k = 0; k < NP; k++) begin
        t_b = m_bank[m_sel[k]];
        n_on[k] = m_on[k]; n_sel[k] = m_sel[k];
        if (m_arm != 0 && b_tap == start_tap(k)) begin
          n_on[k] = (m_bank[t_sn] != 0); n_sel[k] = t_sn;
        end else if (m_on[k] != 0 && t_b != 255 && b_tap == (start_tap(k) + t_b) % 256) begin
          n_on[k] = 0;
        end
      end
      if (m_arm != 0) begin
        t_tgt = 1 - t_sn; t_busy = 0;
        for (int k = 0; k < NP; k++) if (m_on[k] != 0 && m_sel[k] == t_tgt) t_busy = 1;
        t_have = (vld || m_hv != 0);
        t_d = vld ? int'(duty) : m_hold;
        if (t_have != 0) begin
          if (t_busy == 0) begin m_bank[t_tgt] = t_d; m_hv = 0; t_wr = 1; end
          else begin m_hold = t_d; m_hv = 1; end
        end
      end
      for (int k = 0; k < NP; k++) begin
        m_off[k] = (m_on[k] != 0 && n_on[k] == 0);
        m_on[k] = n_on[k]; m_sel[k] = n_sel[k];
      end
      if (t_wr != 0) m_pend = 1; else if (b_tap == 0) m_pend = 0;
      if (b_tap == 0) m_arm = 1;
      m_cur = t_sn;
      b_tap = (b_tap + 1) % 256;
    end
  end

  // per-cycle comparison and pulse-width accumulators
  int acc[NP], acc_off[NP], last_w[NP], last_off[NP];
  logic [3:0] exp_on, exp_off;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < NP; k++) begin exp_on[k] = (m_on[k] != 0); exp_off[k] = (m_off[k] != 0); end
      n_chk++;
      if (pwm_o !== exp_on || off_o !== exp_off) begin
        n_bad++;
        $display("FAIL %s tap %0d: pwm/off act %b/%b exp %b/%b", cur_req, b_tap, pwm_o, off_o, exp_on, exp_off);
      end
      for (int k = 0; k < NP; k++) begin
        if (b_tap == (start_tap(k) + 1) % 256) begin
          last_w[k] = acc[k]; last_off[k] = acc_off[k];
          acc[k] = int'(pwm_o[k]); acc_off[k] = int'(off_o[k]);
        end else begin
          acc[k] += int'(pwm_o[k]); acc_off[k] += int'(off_o[k]);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic to_tap(input int t);
    while (b_tap != t) step();
  endtask

  task automatic send(input int d);
    duty = 8'(d); vld = 1'b1; step(); vld = 1'b0;
  endtask

  // width of the previous period's pulse of phase k, read at tap 64k+1
  task automatic pulse_w(input int k, output int w, output int o);
    to_tap((start_tap(k) + 1) % 256);
    w = last_w[k]; o = last_off[k];
  endtask

  function automatic int rand_duty();
    int r;
    r = int'($urandom % 10);
    if (r == 0) return 0;
    if (r == 1) return 255;
    return int'($urandom % 256);
  endfunction

  initial begin
    int w, o;
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset pwm", int'(pwm_o), 0);
    chk("R1 reset off", int'(off_o), 0);
    rst_n = 1'b1;
    // commands before arming are dropped
    send(50);
    to_tap(0); send(70);
    cur_req = "R2";
    to_tap(20); send(100);
    to_tap(0);
    chk("R2 phase0 low at tap0", int'(pwm_o[0]), 0);
    step();
    chk("R2 phase0 high at tap1", int'(pwm_o[0]), 1);
    pulse_w(1, w, o);
    chk("R1 pre-arm commands ignored", w, 0);
    cur_req = "R3";
    to_tap(100);
    chk("R3 phase0 high at last tap", int'(pwm_o[0]), 1);
    step();
    chk("R3 phase0 low after stop", int'(pwm_o[0]), 0);
    chk("R6 off strobe after fall", int'(off_o[0]), 1);
    step();
    chk("R6 off strobe single cycle", int'(off_o[0]), 0);
    to_tap(200); send(0);
    to_tap(36);
    chk("R3 wrap pulse high at tap36", int'(pwm_o[3]), 1);
    step();
    chk("R3 wrap pulse low at tap37", int'(pwm_o[3]), 0);
    pulse_w(1, w, o);
    chk("R3 width 100", w, 100);
    cur_req = "R4";
    to_tap(200); send(255);
    pulse_w(1, w, o);
    chk("R4 zero duty width", w, 0);
    chk("R4 zero duty no off", o, 0);
    cur_req = "R5";
    to_tap(0); step();
    pulse_w(0, w, o);
    chk("R5 full duty width", w, 256);
    chk("R5 full duty no off", o, 0);
    chk("R5 still high at next start", int'(pwm_o[0]), 1);
    cur_req = "R9";
    to_tap(10); send(200);
    to_tap(0);
    to_tap(10); send(60);
    to_tap(0);
    to_tap(10); send(120);
    pulse_w(1, w, o);
    chk("R7 pulse unaffected by pending command", w, 200);
    cur_req = "R7";
    to_tap(136);
    chk("R7 running pulse keeps stop tap", int'(pwm_o[3]), 1);
    step();
    chk("R7 running pulse ends on time", int'(pwm_o[3]), 0);
    cur_req = "R9";
    pulse_w(1, w, o);
    chk("R9 deferred command period A", w, 60);
    to_tap(0);
    pulse_w(1, w, o);
    chk("R9 deferred command period B", w, 120);
    cur_req = "R8";
    to_tap(100); send(30);
    to_tap(150); send(90);
    pulse_w(1, w, o);
    chk("R7 mid-period commands leave pulse", w, 120);
    to_tap(0);
    pulse_w(1, w, o);
    chk("R8 last command wins", w, 90);
    cur_req = "R3";
    for (int i = 0; i < 60; i++) begin
      to_tap(int'($urandom % 256));
      send(rand_duty());
    end
    repeat (600) step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule